// File: doc/BRIEF.md
# Multiplexed Six-Digit Display Scanner

This block takes a six-digit BCD value and presents it one digit at a time on a shared set of outputs. There are six active-high digit selects, seven segment lines and a four-bit BCD bus. The selects step from the most significant digit to the least significant digit and then wrap. A clock-enable divider turns the system clock into a slower scan tick, and every step of the scan happens on one of these ticks.

A holding register sits between the count input and the scanner. When the transfer control is high, the register follows the count. When it is low, the register keeps its contents, so the display keeps showing a frozen value while the count moves on. Leading zeros are blanked on the segment lines only. The least significant digit is always shown. An unblank input can cancel blanking from a chosen digit to the end of the frame. Lamp test lights every segment and leaves the BCD bus alone.

Each digit slot has three parts. First comes one tick with all selects low. The segment and BCD data change at the end of that tick, and one more tick follows with all selects still low. Then the select for the digit is held high for a parameterised number of ticks. Because of this, no data change ever lines up with a select edge.

Top module: `disp_scan`

## Requirements
- R1: During reset and right after it, all digit selects are low, the BCD bus is 0 and the segment lines are all off (lamp test low).
- R2: At most one select is high at a time. The selects come in the order digit_sel[5], [4], ... [0], then wrap back to digit_sel[5]. digit_sel[5] stands for count[23:20] and digit_sel[0] stands for count[3:0].
- R3: While digit_sel[i] is high, the BCD bus carries nibble i of the held value.
- R4: Segments are active high, with seg[0]=a through seg[6]=g. The digits 0 to 9 use the hex patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. Nibbles 10 to 15 give all segments off.
- R5: When the transfer control is high, the held value follows the count. When it is low, the held value does not change, and both the BCD bus and the segment lines repeat the old value.
- R6: A zero digit that has only zeros (or nothing) to its left shows all segments off. The least significant digit is never blanked. The BCD bus still shows 0 for a blanked digit.
- R7: The unblank input is sampled on the tick that loads a digit, while all selects are low. If it is high, that digit and every later digit in the same frame are shown, even when they are leading zeros.
- R8: When lamp test is high, the segment lines read 7F at once, and the BCD bus does not change.
- R9: A data change on the segment or BCD lines happens only when the selects are low in that cycle and were also low in the cycle before. Between two select-high periods there is always a cycle with all selects low. Data stays constant for as long as one select is high.
- R10: One scan tick occurs every DIV clocks. A select stays high for ON_TICKS*DIV clocks, and the gap between two selects is 2*DIV clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count | input | 24 | Six BCD digits, most significant in [23:20] |
| xfer | input | 1 | High: held value follows count; low: hold |
| lamp_test | input | 1 | High forces all segments on |
| unblank | input | 1 | Cancels leading-zero blanking from the digit being loaded onward |
| digit_sel | output | 6 | One-hot active-high digit select, [5] = most significant |
| seg | output | 7 | Segments a..g on bits 0..6, active high |
| bcd | output | 4 | BCD value of the selected digit |

## Verification
The hardest case to reach is the unblank override taking effect partway through a frame. The input is sampled only on the tick that loads one particular digit. That tick lies inside a window where all selects are low, so no port shows it directly. The bench waits for the previous digit's select to fall and raises unblank inside that gap. It lowers unblank again once the target digit's select rises. It then checks that the digits before the target stay blank while the target and all later digits show zeros. The bench also counts select-high and select-low cycles, and watches the data while a select is high, to check the guard-band timing.

// File: rtl/disp_scan.sv
module disp_scan #(
  parameter int DIGITS   = 6,
  parameter int DIV      = 4,
  parameter int ON_TICKS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIGITS*4-1:0]   count,
  input  logic                  xfer,
  input  logic                  lamp_test,
  input  logic                  unblank,
  output logic [DIGITS-1:0]     digit_sel,
  output logic [6:0]            seg,
  output logic [3:0]            bcd
);
  localparam int DW      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int IW      = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int LAST_PH = ON_TICKS + 1;
  localparam int PW      = $clog2(LAST_PH + 1);
  localparam logic [DIGITS-1:0] MSD_BIT = {1'b1, {(DIGITS-1){1'b0}}};

  logic [DW-1:0]       div_q;
  logic [IW-1:0]       idx;
  logic [PW-1:0]       ph;
  logic [DIGITS*4-1:0] hold_q;
  logic [3:0]          bcd_q;
  logic [6:0]          seg_q;
  logic                zrun;
  logic [3:0]          nib;
  logic                lead, still_zero;

  function automatic logic [6:0] decode(input logic [3:0] v);
    case (v)
      4'd0: decode = 7'h3F;
      4'd1: decode = 7'h06;
      4'd2: decode = 7'h5B;
      4'd3: decode = 7'h4F;
      4'd4: decode = 7'h66;
      4'd5: decode = 7'h6D;
      4'd6: decode = 7'h7D;
      4'd7: decode = 7'h07;
      4'd8: decode = 7'h7F;
      4'd9: decode = 7'h6F;
      default: decode = 7'h00;
    endcase
  endfunction

  wire tick = (div_q == DW'(DIV - 1));

  assign nib        = hold_q[4*(DIGITS-1-int'(idx)) +: 4];
  assign lead       = (idx == '0) ? 1'b1 : zrun;
  assign still_zero = lead && (nib == 4'd0) && !unblank && (idx != IW'(DIGITS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    hold_q <= '0;
    else if (xfer) hold_q <= count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      ph    <= '0;
      bcd_q <= '0;
      seg_q <= '0;
      zrun  <= 1'b1;
    end else if (tick) begin
      if (ph == PW'(LAST_PH)) begin
        ph  <= '0;
        idx <= (idx == IW'(DIGITS-1)) ? '0 : idx + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
      if (ph == '0) begin
        bcd_q <= nib;
        seg_q <= still_zero ? 7'h00 : decode(nib);
        zrun  <= still_zero;
      end
    end
  end

  assign digit_sel = (ph >= PW'(2)) ? (MSD_BIT >> idx) : '0;
  assign bcd       = bcd_q;
  assign seg       = lamp_test ? 7'h7F : seg_q;
endmodule

module disp_scan_chk #(
  parameter int DIGITS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIGITS-1:0] digit_sel,
  input logic [6:0]        seg,
  input logic [3:0]        bcd,
  input logic              lamp_test
);
  logic [DIGITS-1:0] last_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)               last_sel <= '0;
    else if (digit_sel != '0) last_sel <= digit_sel;
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit_sel));

  // R2
  sel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_sel != '0 && $past(digit_sel) == '0 && last_sel != '0)
      |-> digit_sel == {last_sel[0], last_sel[DIGITS-1:1]});

  // R9
  sel_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_sel != '0 && digit_sel != $past(digit_sel)) |-> $past(digit_sel) == '0);

  // R9
  data_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bcd)) |-> (digit_sel == '0 && $past(digit_sel) == '0));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_sel != '0 && digit_sel == $past(digit_sel) && lamp_test == $past(lamp_test))
      |-> ($stable(seg) && $stable(bcd)));
endmodule

bind disp_scan disp_scan_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .digit_sel(digit_sel),
  .seg(seg), .bcd(bcd), .lamp_test(lamp_test)
);

// File: tb/sim_disp_scan.sv
module sim_disp_scan;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int ON_TICKS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] count = '0;
  logic        xfer = 1'b1;
  logic        lamp_test = 1'b0;
  logic        unblank = 1'b0;
  logic [5:0]  digit_sel;
  logic [6:0]  seg;
  logic [3:0]  bcd;

  int checks = 0;
  int failures = 0;

  disp_scan #(.DIGITS(6), .DIV(DIV), .ON_TICKS(ON_TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .count(count), .xfer(xfer),
    .lamp_test(lamp_test), .unblank(unblank),
    .digit_sel(digit_sel), .seg(seg), .bcd(bcd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {count, unblank, lamp}
  localparam logic [25:0] VEC [0:6] = '{
    {24'h123456, 1'b0, 1'b0},
    {24'h000042, 1'b0, 1'b0},
    {24'h000000, 1'b0, 1'b0},
    {24'h0A0709, 1'b0, 1'b0},
    {24'h000100, 1'b1, 1'b0},
    {24'h008000, 1'b0, 1'b1},
    {24'h987650, 1'b0, 1'b0}
  };

  function automatic logic [6:0] pat(input logic [3:0] v);
    logic [6:0] p [0:9] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                            7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (v < 4'd10) ? p[v] : 7'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_sel(input int k);
    while (digit_sel !== (6'b100000 >> k)) @(negedge clk);
  endtask

  task automatic run_frame(input logic [23:0] shown, input logic ub, input logic lamp);
    logic zr;
    zr = 1'b1;
    wait_sel(5);
    for (int k = 0; k < 6; k++) begin
      logic [3:0] v;
      logic       sz;
      logic [6:0] es;
      v  = shown[4*(5-k) +: 4];
      sz = zr && (v == 4'd0) && !ub && (k != 5);
      es = lamp ? 7'h7F : (sz ? 7'h00 : pat(v));
      zr = sz;
      wait_sel(k);
      check("R2/R3 bcd", 32'(bcd), 32'(v));
      check(lamp ? "R8 seg" : "R4/R6 seg", 32'(seg), 32'(es));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 sel", 32'(digit_sel), 0);
    check("R1 bcd", 32'(bcd), 0);
    check("R1 seg", 32'(seg), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sel after", 32'(digit_sel), 0);
    check("R1 seg after", 32'(seg), 0);

    for (int i = 0; i < 7; i++) begin
      count     = VEC[i][25:2];
      unblank   = VEC[i][1];
      lamp_test = VEC[i][0];
      run_frame(VEC[i][25:2], VEC[i][1], VEC[i][0]);
    end
    unblank = 1'b0;
    lamp_test = 1'b0;

    // R5 hold and follow
    count = 24'h111111; xfer = 1'b1;
    run_frame(24'h111111, 1'b0, 1'b0);
    xfer = 1'b0; count = 24'h222222;
    run_frame(24'h111111, 1'b0, 1'b0);
    run_frame(24'h111111, 1'b0, 1'b0);
    xfer = 1'b1;
    run_frame(24'h222222, 1'b0, 1'b0);

    // R7 override from digit 2 onward
    count = 24'h000042;
    wait_sel(5);
    wait_sel(0);
    check("R7 digit0 blank", 32'(seg), 0);
    wait_sel(1);
    check("R7 digit1 blank", 32'(seg), 0);
    while (digit_sel !== 6'b0) @(negedge clk);
    unblank = 1'b1;
    wait_sel(2);
    unblank = 1'b0;
    check("R7 digit2 shown", 32'(seg), 32'h3F);
    wait_sel(3);
    check("R7 digit3 shown", 32'(seg), 32'h3F);
    wait_sel(4);
    check("R7 digit4", 32'(seg), 32'h66);
    wait_sel(0);
    check("R7 next frame blank again", 32'(seg), 0);

    // R10 / R9 timing and stability
    count = 24'h123456;
    wait_sel(5);
    while (digit_sel !== 6'b0) @(negedge clk);
    begin
      int hi, lo, unstable;
      logic [3:0] b0;
      logic [6:0] s0;
      hi = 0; lo = 0; unstable = 0;
      while (digit_sel === 6'b0) @(negedge clk);
      b0 = bcd; s0 = seg;
      while (digit_sel !== 6'b0) begin
        hi++;
        if (bcd !== b0 || seg !== s0) unstable++;
        @(negedge clk);
      end
      while (digit_sel === 6'b0) begin lo++; @(negedge clk); end
      check("R10 high length", 32'(hi), 32'(ON_TICKS*DIV));
      check("R10 gap length", 32'(lo), 32'(2*DIV));
      check("R9 data stable in slot", 32'(unstable), 0);
    end

    // R8 lamp mid-slot, bcd untouched
    wait_sel(3);
    lamp_test = 1'b1;
    @(negedge clk);
    check("R8 lamp seg", 32'(seg), 32'h7F);
    check("R8 lamp bcd", 32'(bcd), 32'h4);
    lamp_test = 1'b0;
    @(negedge clk);
    check("R8 lamp release", 32'(seg), 32'h66);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule